// File: doc/BRIEF.md
# 16-bit ALU and Shift Execute Unit

This block is the integer execute stage of a 16-bit load/store processor. Each cycle it takes an instruction word and the two source operands, which the register file has already read. It decodes the arithmetic, logic and shift operations itself. From these it produces a 16-bit result and a write-enable for the destination register. The destination index is passed straight through from the instruction word.

The datapath is purely combinational, so the result is valid in the same cycle as the inputs. A three-bit one-hot condition register holds negative, zero and positive. It takes the sign class of the result on the clock edge that closes a valid, supported operation.

Fetch, branches, memory access, traps and the register file belong to other blocks.

Top module: `alu_shift_exec`

## Requirements
- R1: The opcode is `instWord[15:12]`. 4'b0001 selects add, 4'b0101 bitwise AND, 4'b1001 bitwise XOR and 4'b1101 shift. For these, while `instValid` is high, `writeEn` is high and `result` holds the operation's value in the same cycle.
- R2: For add, AND and XOR, `instWord[5]` selects the second operand. When it is 0, the operand is `srcB` and bits [4:3] are ignored. When it is 1, the operand is `instWord[4:0]` sign-extended to 16 bits.
- R3: Add wraps modulo 2^16. For example, 0xFFFF + 1 gives 0x0000.
- R4: An XOR with `instWord[5]`=1 and immediate 5'b11111 yields the bitwise complement of `srcA`.
- R5: For a shift, the amount is `instWord[3:0]`, unsigned, from 0 to 15. `instWord[5:4]` selects the shift type: 2'b00 is logical left, 2'b01 is logical right with zero fill, and 2'b11 is arithmetic right, which fills with `srcA[15]`.
- R6: A shift by 0 returns `srcA` unchanged, in all three shift types.
- R7: The shift encoding `instWord[5:4]`=2'b10 and every opcode outside R1 drive `writeEn` low and leave `condFlags` unchanged.
- R8: `condFlags` is one-hot, with bit 2 = N, bit 1 = Z and bit 0 = P. On the clock edge where `instValid` and `writeEn` are both high, it loads the class of `result`: N when bit 15 is set, Z when the result is zero, and P otherwise.
- R9: While `instValid` is low, `writeEn` is low and `condFlags` holds.
- R10: While `rstN` is low, `condFlags` is 3'b010 (Z).
- R11: `destIdx` always equals `instWord[11:9]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction word and operands are valid this cycle |
| instWord | input | 16 | Instruction word |
| srcA | input | 16 | First source operand, read from register file |
| srcB | input | 16 | Second source operand, read from register file |
| result | output | 16 | Combinational result |
| writeEn | output | 1 | Destination register write-enable |
| destIdx | output | 3 | Destination register index |
| condFlags | output | 3 | {N,Z,P} condition register |

## Verification
The bench targets the following corner cases:
- **Immediate sign extension.** An immediate of 5'b10000 must become 0xFFF0. A design that zero-extends gives a positive sum and a P flag where N is expected.
- **Add wrap.** 0xFFFF + 1 must give zero with the Z flag. A design carrying into a wider result shows a nonzero value.
- **Arithmetic right shift of negative values.** A design that zero-fills by mistake turns N into P.
- **Shift amounts of 0 and 15.** These expose barrel stages that are wired with the wrong step.
- **Undefined shift encoding, foreign opcodes and invalid cycles.** Each is placed between flag-changing operations. A design that writes anyway shows `writeEn` high or a flag that has moved.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_XOR = 4'b1001;
  localparam logic [3:0] OPC_SHF = 4'b1101;

  localparam int unsigned IMM_W = 5;

  typedef enum logic [1:0] {
    SEL_ADD   = 2'd0,
    SEL_AND   = 2'd1,
    SEL_XOR   = 2'd2,
    SEL_SHIFT = 2'd3
  } resSel_e;

  typedef struct packed {
    logic    legal;
    logic    useImm;
    resSel_e resSel;
    logic    shRight;
    logic    shArith;
  } ctrlStrobes_t;

endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
(
  input  logic         instValid,
  input  logic [3:0]   opcode,
  input  logic [5:0]   modeBits,
  output ctrlStrobes_t ctrl
);

  logic fmtBit;
  logic dirBit;

  assign fmtBit = modeBits[5];
  assign dirBit = modeBits[4];

  always_comb begin
    ctrl = '{legal: 1'b0, useImm: 1'b0, resSel: SEL_ADD,
             shRight: 1'b0, shArith: 1'b0};
    unique case (opcode)
      OPC_ADD: begin
        ctrl.legal  = 1'b1;
        ctrl.useImm = fmtBit;
        ctrl.resSel = SEL_ADD;
      end
      OPC_AND: begin
        ctrl.legal  = 1'b1;
        ctrl.useImm = fmtBit;
        ctrl.resSel = SEL_AND;
      end
      OPC_XOR: begin
        ctrl.legal  = 1'b1;
        ctrl.useImm = fmtBit;
        ctrl.resSel = SEL_XOR;
      end
      OPC_SHF: begin
        ctrl.resSel  = SEL_SHIFT;
        ctrl.shRight = dirBit;
        ctrl.shArith = fmtBit;
        // arithmetic type with left direction has no meaning
        ctrl.legal   = !(fmtBit && !dirBit);
      end
      default: ctrl.legal = 1'b0;
    endcase
    ctrl.legal = ctrl.legal && instValid;
  end

endmodule

// File: rtl/exec_shifter.sv
module exec_shifter #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dIn,
  input  logic [SH_W-1:0]   amount,
  input  logic              toRight,
  input  logic              arith,
  output logic [DATA_W-1:0] dOut
);

  logic              fillBit;
  logic [DATA_W-1:0] stage [0:SH_W];

  assign fillBit  = arith && dIn[DATA_W-1];
  assign stage[0] = dIn;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int unsigned STEP = 1 << i;
    logic [DATA_W-1:0] leftVal;
    logic [DATA_W-1:0] rightVal;
    assign leftVal  = {stage[i][DATA_W-1-STEP:0], {STEP{1'b0}}};
    assign rightVal = {{STEP{fillBit}}, stage[i][DATA_W-1:STEP]};
    assign stage[i+1] = !amount[i] ? stage[i] : (toRight ? rightVal : leftVal);
  end

  assign dOut = stage[SH_W];

endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import exec_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned SH_W = $clog2(DATA_W)
) (
  input  ctrlStrobes_t      ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  immField,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] operandB;
  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] andVal;
  logic [DATA_W-1:0] xorVal;
  logic [DATA_W-1:0] shiftVal;

  assign immExt   = {{(DATA_W-IMM_W){immField[IMM_W-1]}}, immField};
  assign operandB = ctrl.useImm ? immExt : srcB;

  assign sumVal = srcA + operandB;
  assign andVal = srcA & operandB;
  assign xorVal = srcA ^ operandB;

  exec_shifter #(.DATA_W(DATA_W)) i_shifter (
    .dIn     (srcA),
    .amount  (immField[SH_W-1:0]),
    .toRight (ctrl.shRight),
    .arith   (ctrl.shArith),
    .dOut    (shiftVal)
  );

  always_comb begin
    unique case (ctrl.resSel)
      SEL_ADD:   result = sumVal;
      SEL_AND:   result = andVal;
      SEL_XOR:   result = xorVal;
      SEL_SHIFT: result = shiftVal;
      default:   result = sumVal;
    endcase
  end

endmodule

// File: rtl/exec_ccreg.sv
module exec_ccreg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              update,
  input  logic [DATA_W-1:0] value,
  output logic [2:0]        flags
);

  logic [2:0] nextFlags;

  always_comb begin
    if (value[DATA_W-1])    nextFlags = 3'b100;
    else if (value == '0)   nextFlags = 3'b010;
    else                    nextFlags = 3'b001;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       flags <= 3'b010;
    else if (update) flags <= nextFlags;
  end

endmodule

// File: rtl/alu_shift_exec.sv
module alu_shift_exec
  import exec_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [15:0]       instWord,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [2:0]        destIdx,
  output logic [2:0]        condFlags
);

  ctrlStrobes_t ctrl;

  exec_ctrl i_ctrl (
    .instValid (instValid),
    .opcode    (instWord[15:12]),
    .modeBits  (instWord[5:0]),
    .ctrl      (ctrl)
  );

  exec_datapath #(.DATA_W(DATA_W)) i_datapath (
    .ctrl     (ctrl),
    .srcA     (srcA),
    .srcB     (srcB),
    .immField (instWord[IMM_W-1:0]),
    .result   (result)
  );

  exec_ccreg #(.DATA_W(DATA_W)) i_ccreg (
    .clk    (clk),
    .rstN   (rstN),
    .update (ctrl.legal),
    .value  (result),
    .flags  (condFlags)
  );

  assign writeEn = ctrl.legal;
  assign destIdx = instWord[11:9];

endmodule

// File: rtl/exec_checker.sv
module exec_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [15:0]       instWord,
  input logic [DATA_W-1:0] srcA,
  input logic [DATA_W-1:0] srcB,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic [2:0]        destIdx,
  input logic [2:0]        condFlags
);

  a_r8_flags_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(condFlags) == 1);

  a_r8_flags_follow: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && writeEn) |=>
      condFlags == {$past(result[DATA_W-1]), $past(result) == '0,
                    !$past(result[DATA_W-1]) && $past(result) != '0});

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !writeEn |=> $stable(condFlags));

  a_r9_no_write_invalid: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !writeEn);

  a_r7_undef_shift: assert property (@(posedge clk) disable iff (!rstN)
    (instWord[15:12] == 4'b1101 && instWord[5:4] == 2'b10) |-> !writeEn);

  a_r3_add_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[15:12] == 4'b0001 && !instWord[5]) |->
      (writeEn && result == DATA_W'(srcA + srcB)));

  a_r4_not_form: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[15:12] == 4'b1001 && instWord[5:0] == 6'b111111) |->
      result == ~srcA);

  a_r6_shift_zero: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && instWord[15:12] == 4'b1101 && instWord[3:0] == 4'd0) |->
      result == srcA);

  a_r11_dest_pass: assert property (@(posedge clk) disable iff (!rstN)
    destIdx == instWord[11:9]);

endmodule

bind alu_shift_exec exec_checker #(.DATA_W(DATA_W)) i_exec_checker (.*);

// File: tb/test_alu_shift_exec.sv
module test_alu_shift_exec;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid;
  logic [15:0] instWord;
  logic [15:0] srcA;
  logic [15:0] srcB;
  logic [15:0] result;
  logic        writeEn;
  logic [2:0]  destIdx;
  logic [2:0]  condFlags;

  int total = 0;
  int bad = 0;
  bit active = 1'b0;

  typedef struct {
    logic [15:0] res;
    logic        we;
    logic [2:0]  dst;
    logic [2:0]  flg;
    string       tag;
  } item_t;

  item_t sb[$];
  logic [2:0] modelFlags;

  always #10 clk = ~clk;

  alu_shift_exec i_alu_shift_exec (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .srcA(srcA), .srcB(srcB), .result(result), .writeEn(writeEn),
    .destIdx(destIdx), .condFlags(condFlags)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] classOf(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic drive(input logic [15:0] iw, input logic [15:0] a,
                       input logic [15:0] b, input logic v, input string tag);
    item_t it;
    logic [15:0] opB;
    logic [15:0] r;
    logic ok;
    @(negedge clk);
    instValid = v; instWord = iw; srcA = a; srcB = b;
    opB = iw[5] ? {{11{iw[4]}}, iw[4:0]} : b;
    r = 16'h0;
    ok = 1'b1;
    case (iw[15:12])
      4'b0001: r = a + opB;
      4'b0101: r = a & opB;
      4'b1001: r = a ^ opB;
      4'b1101: case (iw[5:4])
                 2'b00: r = a << iw[3:0];
                 2'b01: r = a >> iw[3:0];
                 2'b11: r = 16'($signed(a) >>> iw[3:0]);
                 default: ok = 1'b0;
               endcase
      default: ok = 1'b0;
    endcase
    ok = ok && v;
    if (ok) modelFlags = classOf(r);
    it.res = r; it.we = ok; it.dst = iw[11:9]; it.flg = modelFlags; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: results and flags sampled after the edge that closes each item
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (active && sb.size() > 0) begin
        it = sb.pop_front();
        check(it.tag, "writeEn", {15'h0, writeEn}, {15'h0, it.we});
        check("R11", "destIdx", {13'h0, destIdx}, {13'h0, it.dst});
        check(it.tag, "condFlags", {13'h0, condFlags}, {13'h0, it.flg});
        if (it.we) check(it.tag, "result", result, it.res);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; instValid = 1'b0; instWord = 16'h0; srcA = 16'h0; srcB = 16'h0;
    modelFlags = 3'b010;
    repeat (3) @(negedge clk);
    check("R10", "reset flags", {13'h0, condFlags}, 16'h0002);
    check("R9", "writeEn idle", {15'h0, writeEn}, 16'h0);
    rstN = 1'b1;
    active = 1'b1;

    // R1 R2: register-form add, dest 3
    drive(16'h1681, 16'h0010, 16'h0020, 1'b1, "R1");
    // R2: register form with bits [4:3] set, still uses srcB
    drive(16'h1299, 16'h0003, 16'h0004, 1'b1, "R2");
    // R2: negative immediate 5'b10000 -> -16
    drive(16'h1230, 16'h0005, 16'h7777, 1'b1, "R2");
    // R3: wrap to zero
    drive(16'h1221, 16'hFFFF, 16'h0000, 1'b1, "R3");
    drive(16'h1000, 16'h8000, 16'h8000, 1'b1, "R3");
    // R1: AND register and immediate
    drive(16'h5000, 16'hF0F0, 16'h3C3C, 1'b1, "R1");
    drive(16'h502F, 16'h8F05, 16'h0000, 1'b1, "R2");
    // R1: XOR register
    drive(16'h9000, 16'h1234, 16'hFFFF, 1'b1, "R1");
    // R4: NOT
    drive(16'h903F, 16'h00FF, 16'h0000, 1'b1, "R4");
    drive(16'h903F, 16'hFFFF, 16'h1111, 1'b1, "R4");
    // R5: left, logical right, arithmetic right
    drive(16'hD004, 16'h0123, 16'h0, 1'b1, "R5");
    drive(16'hD01F, 16'h8000, 16'h0, 1'b1, "R5");
    drive(16'hD03F, 16'h8000, 16'h0, 1'b1, "R5");
    drive(16'hD033, 16'h4F00, 16'h0, 1'b1, "R5");
    drive(16'hD00F, 16'h0001, 16'h0, 1'b1, "R5");
    // R6: zero shift in all types
    drive(16'hD000, 16'h8001, 16'h0, 1'b1, "R6");
    drive(16'hD010, 16'h8001, 16'h0, 1'b1, "R6");
    drive(16'hD030, 16'h8001, 16'h0, 1'b1, "R6");
    // R7: undefined shift encoding and foreign opcodes hold flags (N here)
    drive(16'hD023, 16'h0000, 16'h0, 1'b1, "R7");
    drive(16'h0E05, 16'h0000, 16'h0, 1'b1, "R7");
    drive(16'hE201, 16'h0000, 16'h0, 1'b1, "R7");
    drive(16'h6000, 16'h0000, 16'h0, 1'b1, "R7");
    // R8: move to P then Z
    drive(16'h1021, 16'h0000, 16'h0, 1'b1, "R8");
    drive(16'h5020, 16'h1234, 16'h0, 1'b1, "R8");
    // R9: invalid add that would have given N
    drive(16'h1000, 16'h8000, 16'h0001, 1'b0, "R9");
    drive(16'h903F, 16'h0000, 16'h0, 1'b0, "R9");

    // mixed stream
    for (int k = 0; k < 300; k++) begin
      logic [15:0] iw;
      logic [3:0] opSel;
      opSel = 4'($urandom_range(0, 7));
      iw = 16'($urandom);
      case (opSel)
        4'd0, 4'd1: iw[15:12] = 4'b0001;
        4'd2:       iw[15:12] = 4'b0101;
        4'd3:       iw[15:12] = 4'b1001;
        4'd4, 4'd5: iw[15:12] = 4'b1101;
        default:    ;
      endcase
      drive(iw, 16'($urandom), 16'($urandom), ($urandom_range(0, 7) != 0), "R8");
    end

    @(negedge clk);
    instValid = 1'b0;
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule